// File: doc/BRIEF.md
# Multiplexed Host Bus Slave Interface

This block is the target side of a 16-bit host bus whose address and data share one set of lines. While the address strobe is high, the block captures the low sixteen address bits from the shared lines and the four upper bits from their own pins. It also captures the byte-lane selection from the high-byte enable and address bit 0. An access is then carried by separate active-low read and write strobes. Each access is qualified by an active-low chip select and by a memory/IO space indicator.

Accesses are decoded against two windows. The first is a small register window in IO space, holding control, event status, event mask and a scratch word. The second is a word-wide memory window in memory space, built from inferable block RAM. A synchronous ready output tells the host when a decoded access may complete. An interrupt output with programmable polarity reports masked events. The shared bus is modelled as a separate input, output and output-enable, so that pad logic can be built around it.

Top module: `hbus_slave`

## Requirements
- R1: The address is captured on every clock edge that samples `ale` high. The upper bits 19..16 are captured as zero unless control bit 6 (upper-address enable) is 1. With reset defaults, an access aimed at the memory window at 0xC0000 decodes to nothing.
- R2: While `cs_n` is high, read and write strobes are ignored. No ready pulse, no bus drive and no register or memory update follow.
- R3: `rdy` is low at the first clock edge that samples an active strobe. It goes high at the second edge after that one, but only if the access decodes to a window. It goes low at the first edge after the strobe ends. Undecoded accesses never raise `rdy`.
- R4: The byte lanes for {`bhe_n`,A0} are: 00 = both lanes, 01 = upper lane only, 10 = lower lane only, 11 = lower lane only. A read presents the whole addressed word on `ad_o` whatever lanes are selected.
- R5: A write commits to the addressed word at the edge that first sees the write strobe released. The data used is the data sampled in the last cycle the strobe was low. Bytes on disabled lanes keep their old value.
- R6: `ad_oe` is high from the edge after a decoded read strobe is sampled low until the edge after it is released, and low at all other times.
- R7: The register window (8 bytes at 0x00300) needs `mio`=0. The memory window (0xC0000, two bytes per word) needs `mio`=1. Setting control bit 1 makes both windows decode for either `mio` value.
- R8: Word offsets in the register window are 0 = control, 1 = event status, 2 = event mask and 3 = scratch. Every register resets to zero. Control bit 0 selects the `irq` polarity: 0 = active low, which is the default, and 1 = active high. `irq` is therefore high, meaning inactive, after reset.
- R9: `irq` is active while any bit is 1 in both the event status and the event mask. It tracks changes one clock edge after the status or mask register updates.
- R10: A status bit is set by a one-cycle pulse on its `evt` line. Writing 1 to a status bit through the lower lane clears it. A set and a clear of the same bit at the same edge leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 16 | Shared address/data lines, inbound |
| ad_o | output | 16 | Read data toward the shared lines |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| ale | input | 1 | Address capture strobe, active high |
| addr_hi | input | 4 | Address bits 19..16 |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bhe_n | input | 1 | High-byte enable, active low |
| cs_n | input | 1 | Chip select, active low |
| mio | input | 1 | Space indicator: 1 = memory, 0 = IO |
| evt | input | 8 | Event pulses that set status bits |
| rdy | output | 1 | Synchronous ready, active high |
| irq | output | 1 | Interrupt, programmable polarity |

## Verification
The two functions that can fall on the same clock edge are a host write-one-to-clear of the event status and a new event pulse on the same bit. The bench lines up an `evt` pulse with the edge that sees the write strobe released. It then reads the status back and expects the bit still set, while another bit cleared in the same write is gone. A second overlap is a write that changes the interrupt polarity or mask while an event is pending. This is judged by sampling `irq` after the update and comparing it with the level worked out from the new settings.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    LANE_BOTH = 2'd0,
    LANE_HIGH = 2'd1,
    LANE_LOW  = 2'd2
  } lane_t;

  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_MASK = 2;
  localparam int REG_SCR  = 3;

  localparam int CTRL_POL    = 0;
  localparam int CTRL_MIODIS = 1;
  localparam int CTRL_HIEN   = 6;

  // {bhe_n, a0}: 00 both, 01 upper, 1x lower
  function automatic lane_t lane_pick(input logic bhe_n, input logic a0);
    if (!bhe_n && !a0)     return LANE_BOTH;
    else if (!bhe_n && a0) return LANE_HIGH;
    else                   return LANE_LOW;
  endfunction

  function automatic logic [1:0] lane_bytes(input lane_t l);
    case (l)
      LANE_BOTH: return 2'b11;
      LANE_HIGH: return 2'b10;
      default:   return 2'b01;
    endcase
  endfunction

endpackage

// File: rtl/hbus_cycle.sv
module hbus_cycle
  import hbus_pkg::*;
#(
  parameter int READY_DLY = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ale,
  input  logic [15:0] ad_i,
  input  logic [3:0]  addr_hi,
  input  logic        hi_en,
  input  logic        bhe_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        hit_reg,
  input  logic        hit_mem,
  output logic [19:0] addr_q,
  output logic [1:0]  be,
  output logic        rd_act,
  output logic        wr_reg,
  output logic        wr_mem,
  output logic [15:0] wdata_q,
  output logic        rdy
);

  localparam int CW = $clog2(READY_DLY + 1);

  lane_t         lane_q;
  logic          strobe, strobe_q, wr_act, wr_act_q;
  logic [CW-1:0] cnt;
  logic [1:0]    win_q;

  assign strobe = !cs_n && (!rd_n || !wr_n);
  assign wr_act = !cs_n && !wr_n;
  assign rd_act = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      lane_q   <= LANE_LOW;
      strobe_q <= 1'b0;
      cnt      <= '0;
      rdy      <= 1'b0;
      wr_act_q <= 1'b0;
      wdata_q  <= '0;
      win_q    <= '0;
    end else begin
      if (ale) begin
        addr_q <= {(hi_en ? addr_hi : 4'h0), ad_i};
        lane_q <= lane_pick(bhe_n, ad_i[0]);
      end
      strobe_q <= strobe;
      if (!strobe)                    cnt <= '0;
      else if (cnt != CW'(READY_DLY)) cnt <= cnt + 1'b1;
      rdy      <= strobe && (hit_reg || hit_mem) && (cnt == CW'(READY_DLY));
      wr_act_q <= wr_act;
      if (wr_act) begin
        wdata_q <= ad_i;
        win_q   <= {hit_mem, hit_reg};
      end
    end
  end

  assign be     = lane_bytes(lane_q);
  assign wr_reg = wr_act_q && !wr_act && win_q[0];
  assign wr_mem = wr_act_q && !wr_act && win_q[1];

  assert_rdy_start_low_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_q) |=> !rdy);
  assert_rdy_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    rdy |-> $past(strobe));
  assert_hi_gate_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(ale) && !$past(hi_en)) |-> (addr_q[19:16] == 4'h0));
  assert_lane_low_only_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(ale) && $past(bhe_n)) |-> (be == 2'b01));

endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
  import hbus_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       idx,
  input  logic [1:0]       be,
  input  logic [15:0]      wdata,
  input  logic [EVT_W-1:0] evt,
  output logic [15:0]      rdata,
  output logic             hi_en,
  output logic             mio_dis,
  output logic             irq
);

  logic [15:0]      ctrl, scr;
  logic [EVT_W-1:0] status, mask, clr;
  logic             pend;

  assign clr  = (wr_en && idx == 2'(REG_STAT) && be[0]) ? wdata[EVT_W-1:0] : '0;
  assign pend = |(status & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      scr    <= '0;
      status <= '0;
      mask   <= '0;
      irq    <= 1'b1;
    end else begin
      status <= (status & ~clr) | evt;
      if (wr_en) begin
        case (idx)
          2'(REG_CTRL): begin
            if (be[0]) ctrl[7:0]  <= wdata[7:0];
            if (be[1]) ctrl[15:8] <= wdata[15:8];
          end
          2'(REG_MASK): if (be[0]) mask <= wdata[EVT_W-1:0];
          2'(REG_SCR): begin
            if (be[0]) scr[7:0]  <= wdata[7:0];
            if (be[1]) scr[15:8] <= wdata[15:8];
          end
          default: ;
        endcase
      end
      irq <= ctrl[CTRL_POL] ? pend : !pend;
    end
  end

  always_comb begin
    case (idx)
      2'(REG_CTRL): rdata = ctrl;
      2'(REG_STAT): rdata = {{(16-EVT_W){1'b0}}, status};
      2'(REG_MASK): rdata = {{(16-EVT_W){1'b0}}, mask};
      default:      rdata = scr;
    endcase
  end

  assign hi_en   = ctrl[CTRL_HIEN];
  assign mio_dis = ctrl[CTRL_MIODIS];

  assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~evt)) |=> ((status & $past(clr & ~evt)) == '0));
  assert_evt_sets_R10: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));
  assert_irq_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq);

endmodule

// File: rtl/hbus_mem.sv
module hbus_mem #(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [1:0]    be,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);

  logic [15:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we && be[0]) ram[waddr][7:0]  <= wdata[7:0];
    if (we && be[1]) ram[waddr][15:8] <= wdata[15:8];
    rdata <= ram[raddr];
  end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter logic [19:0] REG_BASE  = 20'h00300,
  parameter logic [19:0] MEM_BASE  = 20'hC0000,
  parameter int          MEM_WORDS = 256,
  parameter int          READY_DLY = 2,
  parameter int          EVT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      ad_i,
  output logic [15:0]      ad_o,
  output logic             ad_oe,
  input  logic             ale,
  input  logic [3:0]       addr_hi,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             bhe_n,
  input  logic             cs_n,
  input  logic             mio,
  input  logic [EVT_W-1:0] evt,
  output logic             rdy,
  output logic             irq
);

  localparam int MEM_AW = $clog2(MEM_WORDS);

  logic [19:0]       addr_q;
  logic [1:0]        be;
  logic              rd_act, wr_reg, wr_mem, hi_en, mio_dis;
  logic              reg_win, mem_win, hit_reg, hit_mem;
  logic [15:0]       wdata_q, reg_rdata, mem_rdata;
  logic [MEM_AW-1:0] mem_idx;
  logic              unused_a0;

  assign unused_a0 = addr_q[0];
  assign reg_win   = (addr_q[19:3] == REG_BASE[19:3]);
  assign mem_win   = (addr_q[19:MEM_AW+1] == MEM_BASE[19:MEM_AW+1]);
  assign hit_reg   = reg_win && (mio_dis || !mio);
  assign hit_mem   = mem_win && (mio_dis || mio);
  assign mem_idx   = addr_q[MEM_AW:1];

  hbus_cycle #(.READY_DLY(READY_DLY)) u_cycle (
    .clk(clk), .rst(rst), .ale(ale), .ad_i(ad_i), .addr_hi(addr_hi),
    .hi_en(hi_en), .bhe_n(bhe_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hit_reg(hit_reg), .hit_mem(hit_mem), .addr_q(addr_q), .be(be),
    .rd_act(rd_act), .wr_reg(wr_reg), .wr_mem(wr_mem), .wdata_q(wdata_q),
    .rdy(rdy)
  );

  hbus_regs #(.EVT_W(EVT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_reg), .idx(addr_q[2:1]), .be(be),
    .wdata(wdata_q), .evt(evt), .rdata(reg_rdata), .hi_en(hi_en),
    .mio_dis(mio_dis), .irq(irq)
  );

  hbus_mem #(.WORDS(MEM_WORDS), .AW(MEM_AW)) u_mem (
    .clk(clk), .we(wr_mem), .be(be), .waddr(mem_idx), .wdata(wdata_q),
    .raddr(mem_idx), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_o  <= '0;
      ad_oe <= 1'b0;
    end else begin
      ad_o  <= hit_reg ? reg_rdata : mem_rdata;
      ad_oe <= rd_act && (hit_reg || hit_mem);
    end
  end

  assert_cs_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> (!ad_oe && !rdy));
  assert_oe_read_R6: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> $past(!rd_n));
  assert_no_dual_hit_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_reg && wr_mem));

endmodule

// File: tb/test_hbus_slave.sv
module test_hbus_slave;

  logic        clk = 1'b0, rst = 1'b1;
  logic [15:0] ad_i = '0, ad_o;
  logic        ad_oe, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, bhe_n = 1'b1;
  logic        cs_n = 1'b1, mio = 1'b0, rdy, irq;
  logic [3:0]  addr_hi = '0;
  logic [7:0]  evt = '0;

  int vecs = 0, bad = 0;
  logic [15:0] mem_m [256];
  logic [15:0] scr_m = '0;
  logic [15:0] rd;

  localparam logic [19:0] A_CTRL = 20'h00300, A_STAT = 20'h00302,
                          A_MASK = 20'h00304, A_SCR  = 20'h00306,
                          A_MEM  = 20'hC0000;

  always #10 clk = ~clk;

  hbus_slave i_hbus_slave (
    .clk(clk), .rst(rst), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .ale(ale),
    .addr_hi(addr_hi), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .cs_n(cs_n),
    .mio(mio), .evt(evt), .rdy(rdy), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic bhe, input logic a0);
    case ({bhe, a0})
      2'b00:   return d;
      2'b01:   return {d[15:8], old[7:0]};
      default: return {old[15:8], d[7:0]};
    endcase
  endfunction

  // one complete host access; rdy and ad_oe timing checked along the way
  task automatic access(input bit is_wr, input logic [19:0] a, input bit m,
                        input bit bhe, input logic [15:0] d, input bit exp_hit,
                        input bit cs_off, input logic [7:0] evt_end,
                        output logic [15:0] q);
    @(negedge clk);
    ale = 1'b1; ad_i = a[15:0]; addr_hi = a[19:16]; mio = m; bhe_n = bhe; cs_n = cs_off;
    @(negedge clk);
    ale = 1'b0;
    ad_i = is_wr ? d : 16'($urandom);
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk);
    chk("R3 rdy low at strobe start", rdy, 0);
    if (!is_wr) chk("R6/R2 ad_oe during read", ad_oe, exp_hit);
    @(negedge clk);
    chk("R3 rdy low one edge later", rdy, 0);
    @(negedge clk);
    chk("R3 rdy high two edges after detect", rdy, exp_hit);
    q = ad_o;
    wr_n = 1'b1; rd_n = 1'b1; evt = evt_end;
    @(negedge clk);
    evt = '0;
    chk("R6 ad_oe released", ad_oe, 0);
    chk("R3 rdy low after strobe", rdy, 0);
    cs_n = 1'b1;
  endtask

  task automatic wr(input logic [19:0] a, input bit m, input bit bhe,
                    input logic [15:0] d, input bit hit);
    logic [15:0] junk;
    access(1'b1, a, m, bhe, d, hit, 1'b0, 8'h00, junk);
  endtask

  task automatic rd_chk(input string tag, input logic [19:0] a, input bit m,
                        input logic [15:0] exp);
    logic [15:0] q;
    access(1'b0, a, m, 1'b0, 16'h0, 1'b1, 1'b0, 8'h00, q);
    chk(tag, q, exp);
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R3 act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk("R8 irq inactive after reset", irq, 1);
    chk("R3 rdy low after reset", rdy, 0);
    chk("R6 ad_oe low after reset", ad_oe, 0);
    rd_chk("R8 ctrl resets to zero", A_CTRL, 1'b0, 16'h0000);
    rd_chk("R8 mask resets to zero", A_MASK, 1'b0, 16'h0000);

    // R1: memory window unreachable while upper-address enable is off
    wr(A_MEM, 1'b1, 1'b0, 16'hBEEF, 1'b0);
    access(1'b0, A_MEM, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 8'h00, rd);

    // R2: chip select high, nothing happens
    access(1'b1, A_SCR, 1'b0, 1'b0, 16'hDEAD, 1'b0, 1'b1, 8'h00, rd);
    access(1'b0, A_SCR, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 8'h00, rd);
    rd_chk("R2 write ignored without chip select", A_SCR, 1'b0, 16'h0000);

    // R7: register window rejects memory space
    wr(A_SCR, 1'b1, 1'b0, 16'h5555, 1'b0);
    rd_chk("R7 register write in memory space ignored", A_SCR, 1'b0, 16'h0000);

    // R4/R5: byte lanes
    wr(A_SCR, 1'b0, 1'b0, 16'hA5C3, 1'b1);
    rd_chk("R4 word transfer", A_SCR, 1'b0, 16'hA5C3);
    wr(A_SCR | 20'h1, 1'b0, 1'b0, 16'h1277, 1'b1);
    rd_chk("R4 upper-byte transfer", A_SCR, 1'b0, 16'h12C3);
    wr(A_SCR, 1'b0, 1'b1, 16'h9934, 1'b1);
    rd_chk("R5 lower-byte keeps upper", A_SCR, 1'b0, 16'h1234);
    wr(A_SCR | 20'h1, 1'b0, 1'b1, 16'h8856, 1'b1);
    rd_chk("R4 high-enable off, A0 odd is lower byte", A_SCR, 1'b0, 16'h1256);
    scr_m = 16'h1256;

    // R1: turn on upper-address bits
    wr(A_CTRL, 1'b0, 1'b0, 16'h0040, 1'b1);
    rd_chk("R1 ctrl readback", A_CTRL, 1'b0, 16'h0040);
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = 16'($urandom);
      wr(A_MEM + 20'(2 * i), 1'b1, 1'b0, mem_m[i], 1'b1);
    end
    rd_chk("R1 memory window reachable after enable", A_MEM, 1'b1, mem_m[0]);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom % 4;
      int w = $urandom % 256;
      bit b = 1'($urandom);
      bit a0 = 1'($urandom);
      logic [15:0] d = 16'($urandom);
      case (op)
        0: begin
          wr(A_MEM + 20'(2 * w) + 20'(a0), 1'b1, b, d, 1'b1);
          mem_m[w] = merge(mem_m[w], d, b, a0);
        end
        1: begin
          access(1'b0, A_MEM + 20'(2 * w) + 20'(a0), 1'b1, b, 16'h0, 1'b1, 1'b0, 8'h00, rd);
          chk("R4/R5 memory read whole word", rd, mem_m[w]);
        end
        2: begin
          wr(A_SCR + 20'(a0), 1'b0, b, d, 1'b1);
          scr_m = merge(scr_m, d, b, a0);
        end
        default: rd_chk("R5 scratch read", A_SCR, 1'b0, scr_m);
      endcase
    end

    // R7: space qualifier disabled
    wr(A_CTRL, 1'b0, 1'b0, 16'h0042, 1'b1);
    wr(A_SCR, 1'b1, 1'b0, 16'h0F0F, 1'b1);
    rd_chk("R7 register hit in memory space when disabled", A_SCR, 1'b1, 16'h0F0F);
    wr(A_MEM + 20'h2, 1'b0, 1'b0, 16'h7E7E, 1'b1);
    rd_chk("R7 memory hit in IO space when disabled", A_MEM + 20'h2, 1'b0, 16'h7E7E);
    wr(A_CTRL, 1'b1, 1'b0, 16'h0040, 1'b1);
    access(1'b0, A_SCR, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 8'h00, rd);

    // R9/R10: interrupt
    wr(A_MASK, 1'b0, 1'b0, 16'h0005, 1'b1);
    chk("R9 irq idle with nothing pending", irq, 1);
    pulse(8'h04);
    chk("R9 irq active low on masked event", irq, 0);
    rd_chk("R10 event sets status", A_STAT, 1'b0, 16'h0004);
    pulse(8'h02);
    rd_chk("R10 second event", A_STAT, 1'b0, 16'h0006);
    wr(A_STAT, 1'b0, 1'b0, 16'h0004, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 irq drops after clear", irq, 1);
    rd_chk("R10 write-one clears only that bit", A_STAT, 1'b0, 16'h0002);
    wr(A_CTRL, 1'b0, 1'b0, 16'h0041, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8 active-high polarity idle", irq, 0);
    pulse(8'h01);
    chk("R8 active-high polarity asserted", irq, 1);
    // R10: clear and set of bit 0 at the same edge
    access(1'b1, A_STAT, 1'b0, 1'b0, 16'h0003, 1'b1, 1'b0, 8'h01, rd);
    rd_chk("R10 set wins over clear at same edge", A_STAT, 1'b0, 16'h0001);
    chk("R9 irq still asserted", irq, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule